// File: doc/BRIEF.md
# Interrupt Status and Vector Unit

This unit keeps the sticky event flags of a serial bus controller, together with the interrupt enable mask and the two DMA enables. It drives one interrupt line and two DMA request lines (receive and transmit). Events from the transfer engine arrive as single-cycle set pulses, one wire per flag. Software reaches the unit through a simple 16-bit register port. Reads are combinational, and any side effect of a read takes place at the clock edge on which `reg_rd` is high.

The parameter `REV` selects one of two programming models. In the legacy model (REV below 0x34), status is cleared by reading a vector register. That read returns the position, plus one, of the lowest-numbered pending enabled flag, and clears that flag. In the newer model (REV of 0x34 or more), the vector register reads as zero, status is write-one-to-clear for a fixed subset of flags, and a test write can raise the low six flags at once. Turning on a DMA enable also turns off the interrupt enable of the matching flag, so that one event is not served twice.

Register word addresses on `reg_addr`: 0 mask, 1 status, 2 vector, 3 DMA enables, 4 test (write only). Other addresses read as zero and ignore writes. All register pins are plain control pins with no back-pressure. An access completes in the cycle it is presented.

Top module: `isv_unit`

## Requirements
- R1: Synchronous reset (`rst` high at a clock edge) clears status, mask and DMA enables, and drives `irq`, `dma_rx_req` and `dma_tx_req` low.
- R2: A high bit on `set_pulse` sets the matching status flag at that edge. The flag stays set until it is cleared, and a status read (address 1) returns the flags in bits 11:0.
- R3: `irq` is a register that goes high one clock after status AND mask becomes nonzero, and goes low one clock after it becomes zero.
- R4: The mask register (address 0) keeps bits 4:0 in the legacy model and bits 5:0 in the newer model. Other written bits read back as zero.
- R5: The DMA enable register (address 3) keeps only bit 15 (receive) and bit 7 (transmit).
- R6: A DMA enable write with bit 15 set clears mask bit 3. A DMA enable write with bit 7 set clears mask bit 4.
- R7: `dma_rx_req` is registered from (receive enable AND status bit 3), and `dma_tx_req` from (transmit enable AND status bit 4), each one clock after its inputs change.
- R8: In the legacy model, a vector read (address 2) returns k+1, where k is the lowest bit set in status AND mask, and clears status bit k. It returns 0 and changes nothing when none is set.
- R9: In the newer model, a vector read returns 0 and leaves status unchanged, and a status write clears the flags whose bits are 1 in (write data AND 0x0027). In the legacy model, status writes are ignored.
- R10: A status read returns the live `bus_busy` level in bit 12.
- R11: In the newer model, a test write (address 4) with bit 11 set sets status bits 5:0. In the legacy model it has no effect.
- R12: When a set pulse and a clear (vector read or write-one-to-clear) hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 3 | Register word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects at the edge) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| set_pulse | input | STAT_W | One-cycle set request for each status flag |
| bus_busy | input | 1 | Live bus-busy level, shown in status bit 12 |
| irq | output | 1 | Interrupt request |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
Two things can hit one flag in the same cycle: a set pulse from the engine, and a clear from software, which is a vector read in the legacy model or a write-one-to-clear in the newer one. The bench raises `set_pulse` on the same edge as a vector read that targets that flag, and on the same edge as a status write that clears it. The flag must still read as set afterwards. A following clear with no set pulse must then remove it, which shows that the clear path itself works.

// File: rtl/isv_pkg.sv
package isv_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned DATA_W = 16;

  localparam logic [ADDR_W-1:0] A_MASK   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_VECTOR = 3'd2;
  localparam logic [ADDR_W-1:0] A_DMAEN  = 3'd3;
  localparam logic [ADDR_W-1:0] A_TEST   = 3'd4;

  // revision threshold for the newer programming model
  localparam int unsigned NEW_MODEL_REV = 'h34;

  localparam int unsigned RX_EN_BIT   = 15;
  localparam int unsigned TX_EN_BIT   = 7;
  localparam int unsigned RX_FLAG     = 3;
  localparam int unsigned TX_FLAG     = 4;
  localparam int unsigned BUSY_BIT    = 12;
  localparam int unsigned FORCE_BIT   = 11;
  localparam logic [DATA_W-1:0] W1C_MASK   = 16'h0027;
  localparam logic [DATA_W-1:0] FORCE_SET  = 16'h003F;
endpackage

// File: rtl/isv_cfg_regs.sv
module isv_cfg_regs
  import isv_pkg::*;
#(
  parameter int unsigned MASK_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_mask_i,
  input  logic              wr_dma_i,
  input  logic [MASK_W-1:0] mask_wdata_i,
  input  logic              rx_en_wdata_i,
  input  logic              tx_en_wdata_i,
  output logic [MASK_W-1:0] mask_o,
  output logic              rx_en_o,
  output logic              tx_en_o
);
  logic [MASK_W-1:0] mask_q;
  logic              rx_en_q, tx_en_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q  <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else if (wr_mask_i) begin
      mask_q <= mask_wdata_i;
    end else if (wr_dma_i) begin
      rx_en_q <= rx_en_wdata_i;
      tx_en_q <= tx_en_wdata_i;
      // enabling DMA hands the matching flag over to the DMA path
      if (rx_en_wdata_i) mask_q[RX_FLAG] <= 1'b0;
      if (tx_en_wdata_i) mask_q[TX_FLAG] <= 1'b0;
    end
  end

  assign mask_o  = mask_q;
  assign rx_en_o = rx_en_q;
  assign tx_en_o = tx_en_q;

  // R6: a DMA enable write removes the matching interrupt enable
  a_r6_rx_unmasks: assert property (@(posedge clk) disable iff (rst)
    (wr_dma_i && !wr_mask_i && rx_en_wdata_i) |=> !mask_q[RX_FLAG]);
  a_r6_tx_unmasks: assert property (@(posedge clk) disable iff (rst)
    (wr_dma_i && !wr_mask_i && tx_en_wdata_i) |=> !mask_q[TX_FLAG]);
endmodule

// File: rtl/isv_status_reg.sv
module isv_status_reg #(
  parameter int unsigned STAT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] set_i,
  input  logic [STAT_W-1:0] clr_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q;

  // a set on the same edge as a clear keeps the flag (no lost event)
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_i) | set_i;
  end

  assign stat_o = stat_q;

  // R12: every requested set is visible after the edge, whatever the clear
  a_r12_set_wins: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));

  // R2: flags only fall where a clear was requested
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((($past(stat_q) & ~stat_q) & ~$past(clr_i)) == '0));
endmodule

// File: rtl/isv_vector.sv
module isv_vector #(
  parameter int unsigned STAT_W = 12,
  localparam int unsigned VEC_W = $clog2(STAT_W + 1)
) (
  input  logic [STAT_W-1:0] pend_i,
  output logic [STAT_W-1:0] pick_o,
  output logic [VEC_W-1:0]  vec_o
);
  logic [STAT_W:0] below;

  assign below[0] = 1'b0;
  for (genvar b = 0; b < STAT_W; b++) begin : g_prio
    assign pick_o[b]    = pend_i[b] & ~below[b];
    assign below[b + 1] = below[b] | pend_i[b];
  end

  always_comb begin
    vec_o = '0;
    for (int b = 0; b < STAT_W; b++) begin
      if (pick_o[b]) vec_o = VEC_W'(b + 1);
    end
  end
endmodule

// File: rtl/isv_request.sv
module isv_request
  import isv_pkg::*;
#(
  parameter int unsigned STAT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [STAT_W-1:0] mask_i,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  output logic              irq_o,
  output logic              rx_req_o,
  output logic              tx_req_o
);
  logic irq_q, rx_q, tx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      rx_q  <= 1'b0;
      tx_q  <= 1'b0;
    end else begin
      irq_q <= |(stat_i & mask_i);
      rx_q  <= rx_en_i & stat_i[RX_FLAG];
      tx_q  <= tx_en_i & stat_i[TX_FLAG];
    end
  end

  assign irq_o    = irq_q;
  assign rx_req_o = rx_q;
  assign tx_req_o = tx_q;

  // R3: interrupt lags the pending set by one edge
  a_r3_irq_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_q == $past(|(stat_i & mask_i))));
  // R7: DMA requests lag their flag and enable by one edge
  a_r7_rx_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (rx_q == $past(rx_en_i && stat_i[RX_FLAG])));
  a_r7_tx_lag: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tx_q == $past(tx_en_i && stat_i[TX_FLAG])));
endmodule

// File: rtl/isv_unit.sv
module isv_unit
  import isv_pkg::*;
#(
  parameter int unsigned REV    = 'h20,
  parameter int unsigned STAT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  input  logic [STAT_W-1:0] set_pulse,
  input  logic              bus_busy,
  output logic              irq,
  output logic              dma_rx_req,
  output logic              dma_tx_req
);
  localparam bit          NEWER  = (REV >= NEW_MODEL_REV);
  localparam int unsigned MASK_W = NEWER ? 6 : 5;
  localparam int unsigned VEC_W  = $clog2(STAT_W + 1);

  logic [MASK_W-1:0] mask;
  logic              rx_en, tx_en;
  logic [STAT_W-1:0] stat, stat_set, stat_clr, pend, pick, mask_ext;
  logic [VEC_W-1:0]  vec;
  logic              wr_mask, wr_dma, wr_stat, wr_test, rd_vec;

  assign wr_mask = reg_wr && (reg_addr == A_MASK);
  assign wr_dma  = reg_wr && (reg_addr == A_DMAEN);
  assign wr_stat = reg_wr && (reg_addr == A_STATUS);
  assign wr_test = reg_wr && (reg_addr == A_TEST);
  assign rd_vec  = reg_rd && (reg_addr == A_VECTOR);

  isv_cfg_regs #(.MASK_W(MASK_W)) u_cfg (
    .clk          (clk),
    .rst          (rst),
    .wr_mask_i    (wr_mask),
    .wr_dma_i     (wr_dma),
    .mask_wdata_i (reg_wdata[MASK_W-1:0]),
    .rx_en_wdata_i(reg_wdata[RX_EN_BIT]),
    .tx_en_wdata_i(reg_wdata[TX_EN_BIT]),
    .mask_o       (mask),
    .rx_en_o      (rx_en),
    .tx_en_o      (tx_en)
  );

  assign mask_ext = {{(STAT_W-MASK_W){1'b0}}, mask};
  assign pend     = stat & mask_ext;

  isv_vector #(.STAT_W(STAT_W)) u_vec (
    .pend_i(pend),
    .pick_o(pick),
    .vec_o (vec)
  );

  // model-specific set and clear sources
  if (NEWER) begin : g_newer
    always_comb begin
      stat_clr = wr_stat ? (reg_wdata[STAT_W-1:0] & W1C_MASK[STAT_W-1:0]) : '0;
      stat_set = set_pulse;
      if (wr_test && reg_wdata[FORCE_BIT]) stat_set = set_pulse | FORCE_SET[STAT_W-1:0];
    end

    // R9: the vector address is inert in this model
    a_r9_vector_inert: assert property (@(posedge clk) disable iff (rst)
      (rd_vec && !reg_wr && (set_pulse == '0)) |=> (stat == $past(stat)));
  end else begin : g_legacy
    always_comb begin
      stat_clr = rd_vec ? pick : '0;
      stat_set = set_pulse;
    end

    // R8: a vector read with a pending flag drops exactly that flag
    a_r8_vector_clears: assert property (@(posedge clk) disable iff (rst)
      (rd_vec && (pend != '0) && (set_pulse == '0)) |=> (stat == ($past(stat) & ~$past(pick))));
    // R9: status writes are ignored in this model
    a_r9_status_ro: assert property (@(posedge clk) disable iff (rst)
      (wr_stat && (set_pulse == '0)) |=> (stat == $past(stat)));
  end

  isv_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk   (clk),
    .rst   (rst),
    .set_i (stat_set),
    .clr_i (stat_clr),
    .stat_o(stat)
  );

  isv_request #(.STAT_W(STAT_W)) u_req (
    .clk     (clk),
    .rst     (rst),
    .stat_i  (stat),
    .mask_i  (mask_ext),
    .rx_en_i (rx_en),
    .tx_en_i (tx_en),
    .irq_o   (irq),
    .rx_req_o(dma_rx_req),
    .tx_req_o(dma_tx_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_MASK:   reg_rdata[MASK_W-1:0] = mask;
      A_STATUS: begin
        reg_rdata[STAT_W-1:0] = stat;
        reg_rdata[BUSY_BIT]   = bus_busy;
      end
      A_VECTOR: if (!NEWER) reg_rdata[VEC_W-1:0] = vec;
      A_DMAEN:  begin
        reg_rdata[RX_EN_BIT] = rx_en;
        reg_rdata[TX_EN_BIT] = tx_en;
      end
      default:  reg_rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;
endmodule

// File: tb/isv_unit_tb.sv
module isv_unit_tb_top;
  localparam int CLK_P = 10;
  localparam int SW    = 12;
  localparam int WD    = 5000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    reg_addr = '0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [15:0]   reg_wdata = '0;
  logic [SW-1:0] set_pulse = '0;
  logic          bus_busy = 1'b0;
  logic [15:0]   rd_l, rd_n;
  logic          irq_l, rx_l, tx_l, irq_n, rx_n, tx_n;
  int            n_tests = 0, n_fail = 0;
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  // legacy model
  isv_unit #(.REV('h20), .STAT_W(SW)) dut_i (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rd_l), .set_pulse(set_pulse), .bus_busy(bus_busy),
    .irq(irq_l), .dma_rx_req(rx_l), .dma_tx_req(tx_l));
  // newer model
  isv_unit #(.REV('h34), .STAT_W(SW)) dut_n (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(rd_n), .set_pulse(set_pulse), .bus_busy(bus_busy),
    .irq(irq_n), .dma_rx_req(rx_n), .dma_tx_req(tx_n));

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d, logic [SW-1:0] pulse = '0);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; set_pulse = pulse;
    tick();
    reg_wr = 1'b0; set_pulse = '0;
  endtask

  // read both units; sample combinational data mid-cycle, then take the edge
  task automatic rd(logic [2:0] a, output logic [15:0] vl, output logic [15:0] vn,
                    input logic [SW-1:0] pulse = '0);
    reg_addr = a; reg_rd = 1'b1; set_pulse = pulse;
    #1;
    vl = rd_l; vn = rd_n;
    tick();
    reg_rd = 1'b0; set_pulse = '0;
  endtask

  task automatic pulse(logic [SW-1:0] p);
    set_pulse = p;
    tick();
    set_pulse = '0;
  endtask

  task automatic t_reset();
    logic [15:0] l, n;
    rst = 1'b1; tick(); tick(); rst = 1'b0;
    rd(3'd0, l, n); chk("R1 mask legacy", l, 0); chk("R1 mask newer", n, 0);
    rd(3'd1, l, n); chk("R1 status legacy", l, 0); chk("R1 status newer", n, 0);
    rd(3'd3, l, n); chk("R1 dma legacy", l, 0); chk("R1 dma newer", n, 0);
    chk("R1 outputs", {10'd0, irq_l, rx_l, tx_l, irq_n, rx_n, tx_n}, 0);
  endtask

  task automatic t_set_and_irq();
    logic [15:0] l, n;
    pulse(12'h005);
    rd(3'd1, l, n); chk("R2 status legacy", l, 16'h0005); chk("R2 status newer", n, 16'h0005);
    chk("R3 irq low while masked", {15'd0, irq_l | irq_n}, 0);
    wr(3'd0, 16'h0004);
    chk("R3 irq not yet", {14'd0, irq_l, irq_n}, 0);
    tick();
    chk("R3 irq one clock later", {14'd0, irq_l, irq_n}, 16'h0003);
    wr(3'd0, 16'h0000); tick();
    chk("R3 irq falls", {14'd0, irq_l, irq_n}, 0);
  endtask

  task automatic t_mask_dma();
    logic [15:0] l, n;
    wr(3'd0, 16'hFFFF);
    rd(3'd0, l, n); chk("R4 mask width legacy", l, 16'h001F); chk("R4 mask width newer", n, 16'h003F);
    wr(3'd3, 16'hFFFF);
    rd(3'd3, l, n); chk("R5 dma bits legacy", l, 16'h8080); chk("R5 dma bits newer", n, 16'h8080);
    rd(3'd0, l, n); chk("R6 mask after dma legacy", l, 16'h0007); chk("R6 mask after dma newer", n, 16'h0027);
  endtask

  task automatic t_dma_req();
    pulse(12'h008);
    chk("R7 rx not yet", {14'd0, rx_l, rx_n}, 0);
    tick();
    chk("R7 rx request", {14'd0, rx_l, rx_n}, 16'h0003);
    chk("R7 tx idle", {14'd0, tx_l, tx_n}, 0);
    pulse(12'h010); tick();
    chk("R7 tx request", {14'd0, tx_l, tx_n}, 16'h0003);
  endtask

  task automatic t_busy();
    logic [15:0] l, n;
    bus_busy = 1'b1;
    rd(3'd1, l, n); chk("R10 busy legacy", l, 16'h101D); chk("R10 busy newer", n, 16'h101D);
    bus_busy = 1'b0;
    rd(3'd1, l, n); chk("R10 idle legacy", l, 16'h001D);
  endtask

  task automatic t_vector();
    logic [15:0] l, n;
    rd(3'd2, l, n); chk("R8 first vector", l, 16'd1); chk("R9 vector newer", n, 0);
    rd(3'd2, l, n); chk("R8 second vector", l, 16'd3);
    rd(3'd2, l, n); chk("R8 empty vector", l, 0);
    rd(3'd1, l, n); chk("R8 status after vectors", l, 16'h0018);
    chk("R9 newer status untouched", n, 16'h001D);
  endtask

  task automatic t_w1c_test();
    logic [15:0] l, n;
    pulse(12'h001);
    wr(3'd1, 16'hFFFF);
    rd(3'd1, l, n); chk("R9 status write ignored legacy", l, 16'h0019);
    chk("R9 w1c newer", n, 16'h0018);
    wr(3'd4, 16'h0800);
    rd(3'd1, l, n); chk("R11 no force legacy", l, 16'h0019);
    chk("R11 force newer", n, 16'h003F);
  endtask

  task automatic t_collision();
    logic [15:0] l, n;
    rd(3'd2, l, n, 12'h001);
    chk("R12 vector value", l, 16'd1);
    rd(3'd1, l, n); chk("R12 set beats vector clear", l, 16'h0019);
    wr(3'd1, 16'h0001, 12'h001);
    rd(3'd1, l, n); chk("R12 set beats w1c", n, 16'h003F);
    wr(3'd1, 16'h0001);
    rd(3'd1, l, n); chk("R9 w1c without set", n, 16'h003E);
    rd(3'd2, l, n);
    rd(3'd1, l, n); chk("R8 vector without set", l, 16'h0018);
  endtask

  initial begin
    t_reset();
    t_set_and_irq();
    t_mask_dma();
    t_dma_req();
    t_busy();
    t_vector();
    t_w1c_test();
    t_collision();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WD) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule